// File: doc/BRIEF.md
# Synonym Sweep Controller for a Virtually Indexed Cache

This controller sits next to a 2-way set associative cache of 64 KB that is indexed with virtual address bits and tagged with physical address bits. Pages are 8 KB, while each way spans 32 KB. The two set index bits just above the page offset therefore differ between address spaces that map the same physical line. A single physical line can live in any of four sets per way, which gives eight possible homes.

When the cache misses, the controller is handed the virtual set index and the physical tag of the missed line. It reads the tag array at each of the four candidate sets in turn and compares the stored physical tag of both ways. Every valid copy it finds is removed. A dirty copy is first written back through a request and acknowledge handshake, then invalidated. When the last candidate set has been handled, a one-cycle done pulse tells the refill logic that it may proceed. The data array, the refill path and address translation are outside this block.

The state machine has seven states:
- IDLE waits for a miss.
- READ issues a tag read.
- COMPARE latches the hit and dirty masks.
- PICK chooses the next hit, or moves on to the next alias or finishes.
- WB_WAIT holds the writeback request.
- INVAL clears one line.
- DONE pulses completion.

The transitions are:
- IDLE→READ on an accepted miss.
- READ→COMPARE.
- COMPARE→PICK.
- PICK→WB_WAIT on a dirty hit.
- PICK→INVAL on a clean hit.
- PICK→READ when no hit is left and aliases remain.
- PICK→DONE after the fourth alias.
- WB_WAIT→INVAL on acknowledge.
- INVAL→PICK.
- DONE→IDLE.

Top module: `alias_sweep_ctrl`

## Requirements
- R1: After reset the controller is idle: miss_ready is 1, and tag_rd_en, inv_en, wb_req and done are 0.
- R2: A miss is taken only on a clock edge where miss_valid and miss_ready are both 1. While a sweep runs, miss_ready is 0 and any miss_valid, index or tag presented is ignored. Lines that hold a tag offered during a busy sweep stay valid.
- R3: Each sweep issues exactly four tag reads. The read set index is {alias, vindex[6:0]}, with the alias value in set bits [8:7] (virtual address bits [14:13]) taking 0, 1, 2, 3 in that order. Tag read data is taken one cycle after tag_rd_en.
- R4: A way matches when its valid bit is 1 and its stored 19-bit physical tag equals the miss tag. Every matching location among the eight candidates gets exactly one inv_en cycle with its set and way. No other line is touched.
- R5: For a match whose dirty bit is 1, wb_req is raised with that set and way and held until wb_ack is sampled high. inv_en for that line follows in the next cycle, never before.
- R6: done is high for exactly one cycle. With m matches and w cycles spent with wb_req high, done goes high 12 + 2m + w cycles after the accepting edge. The controller is idle in the following cycle.
- R7: At most one of miss_ready, tag_rd_en, inv_en, wb_req and done is high in any cycle.
- R8: Invalidations follow alias order, and inside one set way 0 is handled before way 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Controller idle, request will be taken |
| miss_vindex | input | 9 | Virtual set index of the missed access |
| miss_ptag | input | 19 | Physical tag (physical address bits [31:13]) |
| tag_rd_en | output | 1 | Tag array read strobe |
| tag_rd_set | output | 9 | Set to read |
| tag_rd_valid | input | 2 | Valid bits of both ways, one cycle after the read |
| tag_rd_dirty | input | 2 | Dirty bits of both ways, one cycle after the read |
| tag_rd_tag | input | 38 | Stored tags, way w at bits [w*19 +: 19] |
| inv_en | output | 1 | Clear the valid bit of one line |
| inv_set | output | 9 | Set to invalidate |
| inv_way | output | 1 | Way to invalidate |
| wb_req | output | 1 | Writeback request for a dirty match |
| wb_set | output | 9 | Set of the line to write back |
| wb_way | output | 1 | Way of the line to write back |
| wb_ack | input | 1 | Writeback finished |
| done | output | 1 | One-cycle pulse: all aliases handled |

## Verification
The hardest situations to reach from the ports need particular tag contents: copies of the same physical line in several alias sets, both ways of one set matching, and dirty copies whose writeback acknowledge comes late. Random tags almost never produce these. The bench therefore plants the miss tag directly into its tag array model at chosen alias locations with random dirty bits. It mixes directed layouts (none, all eight, all dirty, only the last location) with random masks, and it delays wb_ack by a random number of cycles. It also keeps miss_valid asserted with a decoy tag during sweeps, so that the busy-time rule is exercised.

// File: rtl/alias_inv_pkg.sv
package alias_inv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_COMPARE,
        ST_PICK,
        ST_WB_WAIT,
        ST_INVAL,
        ST_DONE
    } sweep_state_e;

endpackage

// File: rtl/alias_step_counter.sv
module alias_step_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] value,
    output logic             at_last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clear) begin
            value <= '0;
        end else if (step) begin
            value <= value + 1'b1;
        end
    end

    assign at_last = &value;

endmodule

// File: rtl/tag_match_unit.sv
module tag_match_unit #(
    parameter int NUM_WAYS = 2,
    parameter int PTAG_W   = 19
) (
    input  logic [NUM_WAYS-1:0]        rd_valid,
    input  logic [NUM_WAYS-1:0]        rd_dirty,
    input  logic [NUM_WAYS*PTAG_W-1:0] rd_tags,
    input  logic [PTAG_W-1:0]          want_tag,
    output logic [NUM_WAYS-1:0]        hit_mask,
    output logic [NUM_WAYS-1:0]        dirty_mask
);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign hit_mask[w]   = rd_valid[w] && (rd_tags[w*PTAG_W +: PTAG_W] == want_tag);
        assign dirty_mask[w] = hit_mask[w] && rd_dirty[w];
    end

endmodule

// File: rtl/low_way_select.sv
module low_way_select #(
    parameter int NUM_WAYS = 2,
    parameter int WAY_W    = 1
) (
    input  logic [NUM_WAYS-1:0] mask,
    output logic                any,
    output logic [WAY_W-1:0]    way,
    output logic [NUM_WAYS-1:0] onehot
);

    always_comb begin
        any    = |mask;
        way    = '0;
        onehot = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (mask[i]) begin
                way       = WAY_W'(i);
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/alias_sweep_ctrl.sv
module alias_sweep_ctrl
    import alias_inv_pkg::*;
#(
    parameter int  LINE_OFF_W = 6,
    parameter int  SET_IDX_W  = 9,
    parameter int  PAGE_OFF_W = 13,
    parameter int  PTAG_W     = 19,
    parameter int  NUM_WAYS   = 2,
    localparam int WAY_W      = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        miss_valid,
    output logic                        miss_ready,
    input  logic [SET_IDX_W-1:0]        miss_vindex,
    input  logic [PTAG_W-1:0]           miss_ptag,
    output logic                        tag_rd_en,
    output logic [SET_IDX_W-1:0]        tag_rd_set,
    input  logic [NUM_WAYS-1:0]         tag_rd_valid,
    input  logic [NUM_WAYS-1:0]         tag_rd_dirty,
    input  logic [NUM_WAYS*PTAG_W-1:0]  tag_rd_tag,
    output logic                        inv_en,
    output logic [SET_IDX_W-1:0]        inv_set,
    output logic [WAY_W-1:0]            inv_way,
    output logic                        wb_req,
    output logic [SET_IDX_W-1:0]        wb_set,
    output logic [WAY_W-1:0]            wb_way,
    input  logic                        wb_ack,
    output logic                        done
);

    // Index bits that lie above the page offset select the synonym sets.
    localparam int ALIAS_W = LINE_OFF_W + SET_IDX_W - PAGE_OFF_W;
    localparam int LOW_W   = SET_IDX_W - ALIAS_W;

    sweep_state_e state_q, state_d;

    logic [LOW_W-1:0]    base_low_q;
    logic [PTAG_W-1:0]   want_tag_q;
    logic [NUM_WAYS-1:0] hit_pend_q;
    logic [NUM_WAYS-1:0] dirty_pend_q;

    logic [ALIAS_W-1:0]  alias_val;
    logic                alias_last;
    logic                alias_clear;
    logic                alias_step;

    logic [NUM_WAYS-1:0] hit_mask;
    logic [NUM_WAYS-1:0] dirty_mask;

    logic                pend_any;
    logic [WAY_W-1:0]    sel_way;
    logic [NUM_WAYS-1:0] sel_onehot;
    logic                sel_dirty;

    logic [SET_IDX_W-1:0] cur_set;
    logic                 accept;

    alias_step_counter #(
        .CNT_W (ALIAS_W)
    ) u_alias_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (alias_clear),
        .step    (alias_step),
        .value   (alias_val),
        .at_last (alias_last)
    );

    tag_match_unit #(
        .NUM_WAYS (NUM_WAYS),
        .PTAG_W   (PTAG_W)
    ) u_match (
        .rd_valid   (tag_rd_valid),
        .rd_dirty   (tag_rd_dirty),
        .rd_tags    (tag_rd_tag),
        .want_tag   (want_tag_q),
        .hit_mask   (hit_mask),
        .dirty_mask (dirty_mask)
    );

    low_way_select #(
        .NUM_WAYS (NUM_WAYS),
        .WAY_W    (WAY_W)
    ) u_pick (
        .mask   (hit_pend_q),
        .any    (pend_any),
        .way    (sel_way),
        .onehot (sel_onehot)
    );

    assign sel_dirty   = |(dirty_pend_q & sel_onehot);
    assign accept      = (state_q == ST_IDLE) && miss_valid;
    assign alias_clear = accept;
    assign alias_step  = (state_q == ST_PICK) && !pend_any && !alias_last;
    assign cur_set     = {alias_val, base_low_q};

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (miss_valid) state_d = ST_READ;
            ST_READ:    state_d = ST_COMPARE;
            ST_COMPARE: state_d = ST_PICK;
            ST_PICK: begin
                if (pend_any)        state_d = sel_dirty ? ST_WB_WAIT : ST_INVAL;
                else if (alias_last) state_d = ST_DONE;
                else                 state_d = ST_READ;
            end
            ST_WB_WAIT: if (wb_ack) state_d = ST_INVAL;
            ST_INVAL:   state_d = ST_PICK;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            base_low_q   <= '0;
            want_tag_q   <= '0;
            hit_pend_q   <= '0;
            dirty_pend_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                base_low_q <= miss_vindex[LOW_W-1:0];
                want_tag_q <= miss_ptag;
            end
            if (state_q == ST_COMPARE) begin
                hit_pend_q   <= hit_mask;
                dirty_pend_q <= dirty_mask;
            end else if (state_q == ST_INVAL) begin
                hit_pend_q   <= hit_pend_q & ~sel_onehot;
                dirty_pend_q <= dirty_pend_q & ~sel_onehot;
            end
        end
    end

    // Outputs decoded from the current state
    always_comb begin
        miss_ready = (state_q == ST_IDLE);
        tag_rd_en  = (state_q == ST_READ);
        inv_en     = (state_q == ST_INVAL);
        wb_req     = (state_q == ST_WB_WAIT);
        done       = (state_q == ST_DONE);
        tag_rd_set = cur_set;
        inv_set    = cur_set;
        wb_set     = cur_set;
        inv_way    = sel_way;
        wb_way     = sel_way;
    end

endmodule

// File: rtl/alias_sweep_chk.sv
module alias_sweep_chk (
    input logic clk,
    input logic rst_n,
    input logic miss_valid,
    input logic miss_ready,
    input logic tag_rd_en,
    input logic inv_en,
    input logic wb_req,
    input logic wb_ack,
    input logic done
);

    // R7
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({miss_ready, tag_rd_en, inv_en, wb_req, done}));

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> tag_rd_en);

    // R3
    read_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_rd_en |=> (!tag_rd_en && !miss_ready && !inv_en));

    // R5
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> wb_req);

    // R5
    inv_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_ack) |=> inv_en);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (miss_ready && !done));

endmodule

bind alias_sweep_ctrl alias_sweep_chk u_alias_sweep_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_ready (miss_ready),
    .tag_rd_en  (tag_rd_en),
    .inv_en     (inv_en),
    .wb_req     (wb_req),
    .wb_ack     (wb_ack),
    .done       (done)
);

// File: tb/test_alias_sweep_ctrl.sv
module test_alias_sweep_ctrl;

    localparam int NSETS = 512;
    localparam int NW    = 2;
    localparam int TW    = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic            miss_valid = 1'b0;
    logic            miss_ready;
    logic [8:0]      miss_vindex = '0;
    logic [TW-1:0]   miss_ptag = '0;
    logic            tag_rd_en;
    logic [8:0]      tag_rd_set;
    logic [NW-1:0]   tag_rd_valid = '0;
    logic [NW-1:0]   tag_rd_dirty = '0;
    logic [NW*TW-1:0] tag_rd_tag = '0;
    logic            inv_en;
    logic [8:0]      inv_set;
    logic            inv_way;
    logic            wb_req;
    logic [8:0]      wb_set;
    logic            wb_way;
    logic            wb_ack = 1'b0;
    logic            done;

    alias_sweep_ctrl i_alias_sweep_ctrl (
        .clk (clk), .rst_n (rst_n),
        .miss_valid (miss_valid), .miss_ready (miss_ready),
        .miss_vindex (miss_vindex), .miss_ptag (miss_ptag),
        .tag_rd_en (tag_rd_en), .tag_rd_set (tag_rd_set),
        .tag_rd_valid (tag_rd_valid), .tag_rd_dirty (tag_rd_dirty),
        .tag_rd_tag (tag_rd_tag),
        .inv_en (inv_en), .inv_set (inv_set), .inv_way (inv_way),
        .wb_req (wb_req), .wb_set (wb_set), .wb_way (wb_way),
        .wb_ack (wb_ack), .done (done)
    );

    // Tag array model
    logic          m_valid [NSETS][NW];
    logic          m_dirty [NSETS][NW];
    logic [TW-1:0] m_tag   [NSETS][NW];

    always @(posedge clk) begin
        if (tag_rd_en) begin
            for (int w = 0; w < NW; w++) begin
                tag_rd_valid[w]         <= m_valid[tag_rd_set][w];
                tag_rd_dirty[w]         <= m_dirty[tag_rd_set][w];
                tag_rd_tag[w*TW +: TW]  <= m_tag[tag_rd_set][w];
            end
        end
        if (inv_en) begin
            m_valid[inv_set][inv_way] <= 1'b0;
            m_dirty[inv_set][inv_way] <= 1'b0;
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [8:0] set_of(input int a, input logic [8:0] vidx);
        return {a[1:0], vidx[6:0]};
    endfunction

    function automatic int count_valid_tag(input logic [TW-1:0] t);
        int n = 0;
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < NW; w++)
                if (m_valid[s][w] && m_tag[s][w] == t) n++;
        return n;
    endfunction

    function automatic int count_valid();
        int n = 0;
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < NW; w++)
                if (m_valid[s][w]) n++;
        return n;
    endfunction

    task automatic fill_random();
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < NW; w++) begin
                m_valid[s][w] = $urandom_range(0, 1) == 1;
                m_dirty[s][w] = $urandom_range(0, 1) == 1;
                m_tag[s][w]   = TW'($urandom);
            end
    endtask

    // bit index = alias*2 + way
    task automatic plant(input logic [8:0] vidx, input logic [TW-1:0] t,
                         input logic [7:0] loc, input logic [7:0] dirt);
        for (int a = 0; a < 4; a++)
            for (int w = 0; w < NW; w++) begin
                if (loc[a*2+w]) begin
                    m_valid[set_of(a, vidx)][w] = 1'b1;
                    m_dirty[set_of(a, vidx)][w] = dirt[a*2+w];
                    m_tag[set_of(a, vidx)][w]   = t;
                end else if (m_tag[set_of(a, vidx)][w] == t) begin
                    m_tag[set_of(a, vidx)][w] = ~t;
                end
            end
    endtask

    task automatic run_miss(input logic [8:0] vidx, input logic [TW-1:0] t, input bit decoy);
        logic [8:0] exp_set [8];
        int         exp_way [8];
        bit         exp_dirty [8];
        int exp_n = 0;
        int nv0, ndec0, cyc, w_cyc, rdk, invk;
        bit acked;
        logic [TW-1:0] dtag;
        dtag = t ^ TW'(19'h5A5A5);
        for (int a = 0; a < 4; a++)
            for (int w = 0; w < NW; w++)
                if (m_valid[set_of(a, vidx)][w] && m_tag[set_of(a, vidx)][w] == t) begin
                    exp_set[exp_n]   = set_of(a, vidx);
                    exp_way[exp_n]   = w;
                    exp_dirty[exp_n] = m_dirty[set_of(a, vidx)][w];
                    exp_n++;
                end
        if (decoy) begin
            m_valid[set_of(1, vidx ^ 9'h015)][0] = 1'b1;
            m_tag[set_of(1, vidx ^ 9'h015)][0]   = dtag;
        end
        nv0   = count_valid();
        ndec0 = count_valid_tag(dtag);

        @(negedge clk);
        check(miss_ready == 1'b1, "R2 ready before miss", miss_ready, 1);
        miss_vindex = vidx;
        miss_ptag   = t;
        miss_valid  = 1'b1;
        @(negedge clk);
        if (decoy) begin
            miss_ptag   = dtag;
            miss_vindex = vidx ^ 9'h015;
        end else begin
            miss_valid = 1'b0;
        end
        cyc = 0; w_cyc = 0; rdk = 0; invk = 0; acked = 0;
        while (cyc < 3000) begin
            if (tag_rd_en) begin
                check(rdk < 4 && tag_rd_set == set_of(rdk, vidx), "R3 read set order",
                      tag_rd_set, set_of(rdk, vidx));
                rdk++;
            end
            if (wb_req) begin
                w_cyc++;
                check(invk < exp_n && wb_set == exp_set[invk] && int'(wb_way) == exp_way[invk]
                      && exp_dirty[invk], "R5 writeback target", {wb_set, wb_way},
                      invk < exp_n ? {exp_set[invk], 1'(exp_way[invk])} : 0);
                wb_ack = ($urandom_range(0, 2) == 0);
                if (wb_ack) acked = 1;
            end else begin
                wb_ack = 1'b0;
            end
            if (inv_en) begin
                check(invk < exp_n && inv_set == exp_set[invk] && int'(inv_way) == exp_way[invk],
                      "R4 R8 invalidate target/order", {inv_set, inv_way},
                      invk < exp_n ? {exp_set[invk], 1'(exp_way[invk])} : 0);
                if (invk < exp_n && exp_dirty[invk])
                    check(acked, "R5 invalidate after ack", acked, 1);
                invk++;
                acked = 0;
            end
            if (decoy && !done)
                check(miss_ready == 1'b0, "R2 busy not ready", miss_ready, 0);
            if (done) begin
                miss_valid = 1'b0;
                break;
            end
            @(negedge clk);
            cyc++;
        end
        check(cyc == 12 + 2*exp_n + w_cyc, "R6 done latency", cyc, 12 + 2*exp_n + w_cyc);
        check(rdk == 4, "R3 read count", rdk, 4);
        check(invk == exp_n, "R4 invalidate count", invk, exp_n);
        @(negedge clk);
        check(!done && miss_ready, "R6 single done pulse then idle", {done, miss_ready}, 1);
        check(count_valid() == nv0 - exp_n, "R4 other lines untouched", count_valid(), nv0 - exp_n);
        for (int a = 0; a < 4; a++)
            for (int w = 0; w < NW; w++)
                check(!(m_valid[set_of(a, vidx)][w] && m_tag[set_of(a, vidx)][w] == t),
                      "R4 alias cleared", m_valid[set_of(a, vidx)][w], 0);
        if (decoy)
            check(count_valid_tag(dtag) == ndec0, "R2 busy request ignored",
                  count_valid_tag(dtag), ndec0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [8:0]    v;
        logic [TW-1:0] t;
        void'($urandom(32'd7));
        fill_random();
        repeat (3) @(negedge clk);
        // R1 reset state
        check(miss_ready == 1'b1, "R1 ready in reset", miss_ready, 1);
        check({tag_rd_en, inv_en, wb_req, done} == 4'b0, "R1 outputs idle in reset",
              {tag_rd_en, inv_en, wb_req, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(miss_ready && !tag_rd_en && !inv_en && !wb_req && !done, "R1 idle after reset",
              {miss_ready, tag_rd_en, inv_en, wb_req, done}, 16);

        // Directed: no match, exact base latency (R6)
        v = 9'h0A5; t = 19'h12345;
        plant(v, t, 8'h00, 8'h00);
        run_miss(v, t, 1'b0);
        // All eight locations, clean (R4, R8)
        v = 9'h133; t = 19'h0BEEF;
        plant(v, t, 8'hFF, 8'h00);
        run_miss(v, t, 1'b0);
        // All eight dirty (R5)
        v = 9'h07F; t = 19'h7ACE1;
        plant(v, t, 8'hFF, 8'hFF);
        run_miss(v, t, 1'b1);
        // Only alias 3, way 1 (R3 last alias)
        v = 9'h1C0; t = 19'h00F0F;
        plant(v, t, 8'h80, 8'h00);
        run_miss(v, t, 1'b0);
        // Both ways of alias 0, way 1 dirty (R8)
        v = 9'h011; t = 19'h3C3C3;
        plant(v, t, 8'h03, 8'h02);
        run_miss(v, t, 1'b1);

        for (int k = 0; k < 25; k++) begin
            v = 9'($urandom);
            t = TW'($urandom);
            plant(v, t, 8'($urandom), 8'($urandom));
            run_miss(v, t, ($urandom_range(0, 1) == 1));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule